// File: doc/BRIEF.md
# Dual-Compare Pulse Timer

This block is an 8-bit up-counter paired with two compare registers, A and B. When a count tick arrives, each compare register is checked against the counter. A match sets a sticky flag. It can also drive a single output pin in one of four ways: leave it alone, force it low, force it high, or toggle it. A clear-select field can return the counter to zero on a match, which sets the period. The two compares together then produce a continuous pulse train whose period and width come from register values alone. No software runs while the pulses are generated.

Software reaches the block through a small synchronous write bus with a combinational read. Through it, software sets the clear select, the two output actions and the compare values, and it can read or preload the counter. It clears flags by writing zero to them. The count-enable tick comes from outside, so any prescaling happens before the block.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both compare registers, the clear select, both action fields and all three flags are 0, and the output pin is 0.
- R2: Register map on `bus_addr`: 0 holds the clear select in bits 1:0; 1 is the status/control register; 2 is compare A; 3 is compare B; 4 is the counter. In the status/control register, bit 7 is the B flag, bit 6 the A flag, bit 5 the overflow flag, bits 3:2 the B action and bits 1:0 the A action. Unused bits and unmapped addresses read 0.
- R3: The counter advances by one on each clock with `tick` high and holds when `tick` is low. A bus write to address 4 loads the counter and wins over an increment in the same cycle.
- R4: Clear select 00 lets the counter run free and wrap from 0xFF to 0x00. 01 clears it to 0 on a compare-A match, 10 clears it on a compare-B match, and 11 behaves like 00.
- R5: The overflow flag is set when an increment takes the counter from 0xFF to 0x00.
- R6: A match occurs when `tick` is high and the counter equals a compare register. The matching flag is set on that same clock edge.
- R7: Each action field uses this encoding: 00 leaves the output unchanged, 01 drives it to 0, 10 drives it to 1, and 11 inverts it. The action takes effect on the edge of the match.
- R8: When A and B match on the same tick, the B action alone decides the output and both flags are set.
- R9: Writing 0 to status bits 7, 6 or 5 clears that flag. Writing 1 to them leaves the flag as it was.
- R10: With clear select 01 and actions 0110 (B drives low, A drives high), the period is compare A + 1 ticks and the output is high for compare B + 1 ticks of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tick | input | 1 | Count enable |
| tmr_out | output | 1 | Timer output pin |
| flag_a | output | 1 | Compare-A match flag |
| flag_b | output | 1 | Compare-B match flag |
| flag_ovf | output | 1 | Counter overflow flag |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `bus_wdata` and `tick` are stable around each rising edge and hold no unknowns once reset is released. The bench keeps to this by changing every input only on falling edges, from tasks. Flag-hold properties assume that software clears a flag only through a status write with that bit at zero. Each directed task therefore writes the action bits together with explicit flag bits, so no scenario clears a flag by accident.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          tick,
  output logic          tmr_out,
  output logic          flag_a,
  output logic          flag_b,
  output logic          flag_ovf
);
  localparam logic [W-1:0]  TOP    = '1;
  localparam logic [AW-1:0] AD_CTL = AW'(0);
  localparam logic [AW-1:0] AD_STS = AW'(1);
  localparam logic [AW-1:0] AD_CMA = AW'(2);
  localparam logic [AW-1:0] AD_CMB = AW'(3);
  localparam logic [AW-1:0] AD_CNT = AW'(4);

  localparam logic [1:0] ACT_KEEP = 2'b00;
  localparam logic [1:0] ACT_LOW  = 2'b01;
  localparam logic [1:0] ACT_HIGH = 2'b10;

  logic [W-1:0] cnt, cmp_a, cmp_b;
  logic [1:0]   clr_sel, act_a, act_b;

  wire wr_ctl = bus_wr && bus_addr == AD_CTL;
  wire wr_sts = bus_wr && bus_addr == AD_STS;
  wire wr_cma = bus_wr && bus_addr == AD_CMA;
  wire wr_cmb = bus_wr && bus_addr == AD_CMB;
  wire wr_cnt = bus_wr && bus_addr == AD_CNT;

  wire hit_a   = tick && cnt == cmp_a;
  wire hit_b   = tick && cnt == cmp_b;
  wire clr_now = (clr_sel == 2'b01 && hit_a) || (clr_sel == 2'b10 && hit_b);
  wire wrap    = tick && !wr_cnt && !clr_now && cnt == TOP;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata;
    else if (tick) cnt <= clr_now ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0; cmp_b <= '0; clr_sel <= '0; act_a <= '0; act_b <= '0;
    end else begin
      if (wr_cma) cmp_a <= bus_wdata;
      if (wr_cmb) cmp_b <= bus_wdata;
      if (wr_ctl) clr_sel <= bus_wdata[1:0];
      if (wr_sts) begin
        act_a <= bus_wdata[1:0];
        act_b <= bus_wdata[3:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0; flag_b <= 1'b0; flag_ovf <= 1'b0;
    end else begin
      if (hit_b) flag_b <= 1'b1;
      else if (wr_sts && !bus_wdata[7]) flag_b <= 1'b0;
      if (hit_a) flag_a <= 1'b1;
      else if (wr_sts && !bus_wdata[6]) flag_a <= 1'b0;
      if (wrap) flag_ovf <= 1'b1;
      else if (wr_sts && !bus_wdata[5]) flag_ovf <= 1'b0;
    end
  end

  function automatic logic apply(input logic [1:0] act, input logic cur);
    case (act)
      ACT_KEEP: apply = cur;
      ACT_LOW:  apply = 1'b0;
      ACT_HIGH: apply = 1'b1;
      default:  apply = !cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_out <= 1'b0;
    else if (hit_b) tmr_out <= apply(act_b, tmr_out);
    else if (hit_a) tmr_out <= apply(act_a, tmr_out);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AD_CTL: bus_rdata[1:0] = clr_sel;
      AD_STS: bus_rdata[7:0] = {flag_b, flag_a, flag_ovf, 1'b0, act_b, act_a};
      AD_CMA: bus_rdata = cmp_a;
      AD_CMB: bus_rdata = cmp_b;
      AD_CNT: bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !bus_wr |=> $stable(cnt)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AD_CNT |=> cnt == $past(bus_wdata)); // R3
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_ovf && cnt == '0); // R5
  AST_FLAG_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == cmp_a |=> flag_a); // R6
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_b && !(bus_wr && bus_addr == AD_STS && !bus_wdata[7]) |=> flag_b); // R9
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == cmp_a) && !(tick && cnt == cmp_b) |=> $stable(tmr_out)); // R7
  AST_B_WINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == cmp_b && act_b == ACT_LOW |=> !tmr_out); // R8
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       tmr_out, flag_a, flag_b, flag_ovf;

  int checks = 0;
  int errors = 0;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .tmr_out(tmr_out), .flag_a(flag_a), .flag_b(flag_b), .flag_ovf(flag_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    repeat (3) @(negedge clk);
    check("R1 out", tmr_out, 0);
    check("R1 flags", {flag_b, flag_a, flag_ovf}, 0);
    rd_check(3'd0, 8'h00, "R1 ctl");
    rd_check(3'd1, 8'h00, "R1 sts");
    rd_check(3'd2, 8'h00, "R1 cmpa");
    rd_check(3'd4, 8'h00, "R3 hold without tick");
    wr(3'd0, 8'hFF); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd1, 8'h1F);
    rd_check(3'd0, 8'h03, "R2 ctl");
    rd_check(3'd1, 8'h0F, "R2 sts");
    rd_check(3'd2, 8'h5A, "R2 cmpa");
    rd_check(3'd3, 8'hC3, "R2 cmpb");
    rd_check(3'd6, 8'h00, "R2 unmapped");
  endtask

  task automatic t_overflow();
    do_reset();
    wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    wr(3'd4, 8'hFE);
    pulse_tick();
    rd_check(3'd4, 8'hFF, "R3 increment");
    check("R5 no ovf yet", flag_ovf, 0);
    pulse_tick();
    rd_check(3'd4, 8'h00, "R4 free wrap");
    check("R5 ovf set", flag_ovf, 1);
  endtask

  task automatic t_toggle();
    do_reset();
    wr(3'd3, 8'h80);
    wr(3'd1, 8'h03); wr(3'd2, 8'h05); wr(3'd4, 8'h05);
    pulse_tick();
    check("R7 toggle up", tmr_out, 1);
    check("R6 flag_a", flag_a, 1);
    rd_check(3'd4, 8'h06, "R3 after match");
    wr(3'd4, 8'h05);
    pulse_tick();
    check("R7 toggle down", tmr_out, 0);
    wr(3'd1, 8'h42); wr(3'd4, 8'h05);
    pulse_tick();
    check("R7 drive high", tmr_out, 1);
    wr(3'd1, 8'h40); wr(3'd4, 8'h05);
    pulse_tick();
    check("R7 keep", tmr_out, 1);
  endtask

  task automatic t_priority();
    do_reset();
    wr(3'd3, 8'h80);
    wr(3'd1, 8'h02); wr(3'd2, 8'h07); wr(3'd4, 8'h07);
    pulse_tick();
    check("R7 high on A", tmr_out, 1);
    wr(3'd1, 8'h06); wr(3'd3, 8'h07); wr(3'd4, 8'h07);
    pulse_tick();
    check("R8 B wins", tmr_out, 0);
    check("R8 both flags", {flag_b, flag_a}, 2'b11);
  endtask

  task automatic t_flags();
    do_reset();
    pulse_tick();
    check("R6 both at zero", {flag_b, flag_a}, 2'b11);
    wr(3'd1, 8'hE0);
    check("R9 write ones", {flag_b, flag_a, flag_ovf}, 3'b110);
    wr(3'd1, 8'hA0);
    check("R9 clear A only", {flag_b, flag_a}, 2'b10);
    rd_check(3'd1, 8'h80, "R9 sts read");
  endtask

  task automatic t_load_prio();
    do_reset();
    wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    @(negedge clk); tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h40;
    @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
    rd_check(3'd4, 8'h40, "R3 load wins");
  endtask

  task automatic t_clear_sel();
    do_reset();
    wr(3'd0, 8'h02); wr(3'd2, 8'h80); wr(3'd3, 8'h03); wr(3'd4, 8'h03);
    pulse_tick();
    rd_check(3'd4, 8'h00, "R4 clear on B");
    wr(3'd0, 8'h03); wr(3'd2, 8'h03); wr(3'd4, 8'h03);
    pulse_tick();
    rd_check(3'd4, 8'h04, "R4 reserved no clear");
  endtask

  task automatic t_pwm();
    int highs = 0;
    int maxc = 0;
    do_reset();
    wr(3'd0, 8'h01); wr(3'd2, 8'h09); wr(3'd3, 8'h03); wr(3'd1, 8'h06);
    bus_addr = 3'd4;
    @(negedge clk); tick = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i > 10 && tmr_out) highs++;
      if (int'(bus_rdata) > maxc) maxc = int'(bus_rdata);
    end
    tick = 1'b0;
    check("R10 high count", highs, 8);
    check("R4 clear on A bound", maxc, 9);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_overflow();
    t_toggle();
    t_priority();
    t_flags();
    t_load_prio();
    t_clear_sel();
    t_pwm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule